// File: doc/BRIEF.md
# Parallel EEPROM Page Write Controller

This block is the internal sequencer of a byte-wide parallel EEPROM. A host loads bytes with single-cycle write strobes. The first strobe of a burst opens a page-load window and fixes the page that the whole burst targets. Every strobe writes its byte into a page-sized holding buffer, at the position given by the low address bits, and restarts a load timer. When the timer runs out with no further strobe, loading is over.

The block then starts one internal programming cycle of fixed length. At the end of that cycle, every byte that was loaded is copied into the storage array in a single step. The length of the cycle does not depend on how many bytes were loaded. While programming runs, `busy` is high and write strobes are discarded. A read of the last address written returns that byte with bit 7 inverted, so the host can poll for completion. Once programming finishes, reads return the true stored data.

Both timeouts are parameters counted in clock cycles. The storage array is an array of registers inside the block.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0 and every byte of the storage array reads as 0.
- R2: `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is sampled. Outside programming, reads return the stored contents, including during the load window, where loaded bytes stay invisible until they are programmed.
- R3: `busy` rises exactly `LOAD_TIMEOUT` cycles after the clock edge that accepted the last strobe. A strobe accepted before that point restarts the count from zero.
- R4: `busy` stays high for exactly `PROG_CYCLES` cycles, whether 1 byte or a full page of 2^`PAGE_BITS` bytes was loaded.
- R5: While `busy` is high, a read of the last address written returns that byte with bit 7 inverted and bits 6..0 unchanged.
- R6: After `busy` falls, every loaded byte reads back with its true value.
- R7: Bytes of the page that were not loaded keep their previous contents, and no other page changes.
- R8: The page is the address above bit `PAGE_BITS`-1 of the first strobe of a burst. Later strobes in the same burst use only their low `PAGE_BITS` address bits as the offset within that page.
- R9: Strobes that arrive while `busy` is high change no stored byte and do not start a new load window.
- R10: If the same offset is loaded twice in one burst, the later data is the data programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Single-cycle byte load strobe |
| wr_addr | input | ADDR_W | Byte address for the strobe |
| wr_data | input | 8 | Byte to load |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data, with the bit 7 inversion applied during polling |
| busy | output | 1 | High while the internal programming cycle runs |

## Verification
A load timer that counts wrongly shows up at `busy`: the rise comes early, late, or not at all during a retriggered burst. The bench sees this within `LOAD_TIMEOUT` cycles of the last strobe, and the checker flags it on the rising edge of `busy`. A wrong captured page or a wrong last offset shows up at the first polling read as a missing bit 7 inversion. A buffer mask or commit fault shows up only after `busy` falls, as a wrong readback of a loaded byte or a changed neighbouring byte. The bench reads those bytes back right after programming completes.

// File: rtl/eeprom_pg_pkg.sv
// Shared types for the EEPROM page write controller.
package eeprom_pg_pkg;
    typedef logic [7:0] ee_byte_t;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_FILL = 2'd1,
        PG_BURN = 2'd2
    } pg_state_e;
endpackage

// File: rtl/ee_cycle_timer.sv
// Cycle timer used both as the retriggerable load one-shot and as the
// programming-time counter.
// Assumes: TICKS >= 1. The count is held at zero while run is low or
// restart is high. expire pulses on the edge that ends the TICKS-th
// cycle of an uninterrupted run.
module ee_cycle_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Count the cycles since the last restart while running; saturate at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/ee_page_buffer.sv
// Holding buffer for one page: a data byte and a loaded flag per offset.
// Assumes: clear and wr_en are never high in the same cycle, because the
// owner only clears at the end of programming, when strobes are refused.
module ee_page_buffer
    import eeprom_pg_pkg::*;
#(
    parameter int PAGE_BITS = 7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [PAGE_BITS-1:0]               wr_off,
    input  ee_byte_t                           wr_data,
    input  logic                               clear,
    output logic [(1 << PAGE_BITS)-1:0][7:0]   page_data,
    output logic [(1 << PAGE_BITS)-1:0]        page_mask
);
    localparam int PB = 1 << PAGE_BITS;

    for (genvar i = 0; i < PB; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == PAGE_BITS'(i));

        // Hold one buffered byte; set its loaded flag on a write, drop it on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_data[i] <= '0;
                page_mask[i] <= 1'b0;
            end else if (clear) begin
                page_mask[i] <= 1'b0;
            end else if (hit) begin
                page_data[i] <= wr_data;
                page_mask[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ee_byte_array.sv
// Byte storage array with a page-wide commit port and a combinational
// read port.
// Assumes: PAGE_BITS < ADDR_W. A commit writes only the masked offsets
// of the selected page, all in one cycle.
module ee_byte_array
    import eeprom_pg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  logic [ADDR_W-PAGE_BITS-1:0]        commit_page,
    input  logic [(1 << PAGE_BITS)-1:0][7:0]   page_data,
    input  logic [(1 << PAGE_BITS)-1:0]        page_mask,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output ee_byte_t                           rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PB    = 1 << PAGE_BITS;

    ee_byte_t mem [DEPTH];

    // Clear on reset; on commit, write every loaded byte of the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < PB; i++) begin
                if (page_mask[i]) begin
                    mem[{commit_page, PAGE_BITS'(i)}] <= page_data[i];
                end
            end
        end
    end

    assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_prog.sv
// EEPROM page write controller (top).
// The first strobe opens a load window and fixes the page. Each accepted
// strobe restarts the load timer. When the timer expires, a programming
// cycle of PROG_CYCLES runs; at its last edge the buffered bytes are
// committed. Reads are registered and show the bit 7 inversion for the
// polled address while programming.
// Assumes: LOAD_TIMEOUT >= 1, PROG_CYCLES >= 1, PAGE_BITS < ADDR_W.
module eeprom_page_prog
    import eeprom_pg_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PAGE_BITS    = 7,
    parameter int LOAD_TIMEOUT = 7500,
    parameter int PROG_CYCLES  = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int PW = ADDR_W - PAGE_BITS;
    localparam int PB = 1 << PAGE_BITS;

    pg_state_e              state_q;
    logic [PW-1:0]          page_q;
    logic [PAGE_BITS-1:0]   last_off_q;
    ee_byte_t               last_data_q;
    ee_byte_t               rd_data_q;

    logic                   accept;
    logic                   fill_expire;
    logic                   burn_expire;
    logic                   poll_hit;
    ee_byte_t               arr_byte;
    logic [PB-1:0][7:0]     buf_data;
    logic [PB-1:0]          buf_mask;

    assign accept = wr_stb && (state_q != PG_BURN);

    ee_cycle_timer #(.TICKS(LOAD_TIMEOUT)) u_load_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == PG_FILL),
        .restart (accept),
        .expire  (fill_expire)
    );

    ee_cycle_timer #(.TICKS(PROG_CYCLES)) u_prog_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == PG_BURN),
        .restart (1'b0),
        .expire  (burn_expire)
    );

    ee_page_buffer #(.PAGE_BITS(PAGE_BITS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_off    (wr_addr[PAGE_BITS-1:0]),
        .wr_data   (wr_data),
        .clear     (burn_expire),
        .page_data (buf_data),
        .page_mask (buf_mask)
    );

    ee_byte_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (burn_expire),
        .commit_page (page_q),
        .page_data   (buf_data),
        .page_mask   (buf_mask),
        .rd_addr     (rd_addr),
        .rd_byte     (arr_byte)
    );

    // Sequence idle -> fill -> burn -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
        end else begin
            unique case (state_q)
                PG_IDLE: if (accept)      state_q <= PG_FILL;
                PG_FILL: if (fill_expire) state_q <= PG_BURN;
                PG_BURN: if (burn_expire) state_q <= PG_IDLE;
                default:                  state_q <= PG_IDLE;
            endcase
        end
    end

    // Capture the page on the opening strobe and remember the last byte loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q      <= '0;
            last_off_q  <= '0;
            last_data_q <= '0;
        end else if (accept) begin
            if (state_q == PG_IDLE) begin
                page_q <= wr_addr[ADDR_W-1:PAGE_BITS];
            end
            last_off_q  <= wr_addr[PAGE_BITS-1:0];
            last_data_q <= wr_data;
        end
    end

    assign poll_hit = (state_q == PG_BURN) && (rd_addr == {page_q, last_off_q});

    // Register read data, with bit 7 inverted for polling reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (poll_hit) begin
            rd_data_q <= {~last_data_q[7], last_data_q[6:0]};
        end else begin
            rd_data_q <= arr_byte;
        end
    end

    assign rd_data = rd_data_q;
    assign busy    = (state_q == PG_BURN);
endmodule

// File: rtl/eeprom_page_prog_chk.sv
// Checker for eeprom_page_prog, attached by bind. It rebuilds the
// expected timing and the polled address from the ports only.
module eeprom_page_prog_chk #(
    parameter int ADDR_W       = 10,
    parameter int PAGE_BITS    = 7,
    parameter int LOAD_TIMEOUT = 7500,
    parameter int PROG_CYCLES  = 300000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              busy
);
    localparam int GW = $clog2(LOAD_TIMEOUT + 2) + 1;
    localparam int BW = $clog2(PROG_CYCLES + 2) + 1;
    localparam int PW = ADDR_W - PAGE_BITS;

    logic                 ld_act;
    logic [GW-1:0]        gap;
    logic [BW-1:0]        bcnt;
    logic [PW-1:0]        pg;
    logic [PAGE_BITS-1:0] lst_off;
    logic [7:0]           lst_data;

    // Follow the load window and the length of the busy interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_act   <= 1'b0;
            gap      <= '0;
            bcnt     <= '0;
            pg       <= '0;
            lst_off  <= '0;
            lst_data <= '0;
        end else begin
            if (wr_stb && !busy) begin
                ld_act   <= 1'b1;
                gap      <= '0;
                lst_off  <= wr_addr[PAGE_BITS-1:0];
                lst_data <= wr_data;
                if (!ld_act) pg <= wr_addr[ADDR_W-1:PAGE_BITS];
            end else if (busy) begin
                ld_act <= 1'b0;
            end else if (ld_act) begin
                gap <= gap + 1'b1;
            end
            bcnt <= busy ? bcnt + 1'b1 : '0;
        end
    end

    a_r3_load_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ld_act && gap == GW'(LOAD_TIMEOUT)));

    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_act && !busy) |-> (gap < GW'(LOAD_TIMEOUT)));

    a_r4_burn_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == BW'(PROG_CYCLES)));

    a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < BW'(PROG_CYCLES)));

    a_r5_poll_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_addr == {pg, lst_off}) |=> (rd_data == {~lst_data[7], lst_data[6:0]}));
endmodule

bind eeprom_page_prog eeprom_page_prog_chk #(
    .ADDR_W       (ADDR_W),
    .PAGE_BITS    (PAGE_BITS),
    .LOAD_TIMEOUT (LOAD_TIMEOUT),
    .PROG_CYCLES  (PROG_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .busy    (busy)
);

// File: tb/eeprom_page_prog_tb.sv
module eeprom_page_prog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int PBITS = 7;
    localparam int LT = 12;
    localparam int PC = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int  n_checks = 0;
    int  n_errors = 0;
    int  cyc = 0;
    bit  finished = 1'b0;

    logic [7:0] model [1 << AW];
    int         pend_off [$];
    logic [7:0] pend_dat [$];
    int         cur_pg = 0;
    logic [7:0] last_dat = '0;

    int         q_stamp [$];
    logic [7:0] q_exp   [$];
    int         q_addr  [$];
    string      q_tag   [$];

    eeprom_page_prog #(
        .ADDR_W(AW), .PAGE_BITS(PBITS), .LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Scoreboard monitor: compare each read result in the cycle it appears.
    always @(negedge clk) begin
        while (q_stamp.size() > 0 && q_stamp[0] == cyc) begin
            check(rd_data == q_exp[0], $sformatf("%s rd@0x%0h", q_tag[0], q_addr[0]),
                  rd_data, q_exp[0]);
            void'(q_stamp.pop_front());
            void'(q_exp.pop_front());
            void'(q_addr.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raw strobe for one cycle.
    task automatic wr(input int a, input logic [7:0] d);
        wr_stb  = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // Driver: strobe a byte and record its expected placement (R8, R10).
    task automatic ld(input int a, input logic [7:0] d);
        if (pend_off.size() == 0) cur_pg = a >> PBITS;
        pend_off.push_back(a & ((1 << PBITS) - 1));
        pend_dat.push_back(d);
        last_dat = d;
        wr(a, d);
    endtask

    // Driver: issue a read and push the expected result.
    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        rd_addr = AW'(a);
        q_stamp.push_back(cyc + 1);
        q_exp.push_back(exp);
        q_addr.push_back(a);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Wait out the load window, poll during programming, then apply the model.
    task automatic run_window(input int poll_a, input bit inject);
        logic [7:0] pexp;
        pexp = {~last_dat[7], last_dat[6:0]};
        idle(LT - 1);
        check(busy == 1'b0, "R3 busy low inside load window", busy, 0);
        idle(1);
        check(busy == 1'b1, "R3 busy rises at load timeout", busy, 1);
        for (int k = 0; k < 3; k++) rd(poll_a, pexp, "R5 poll");
        if (inject) begin
            wr(poll_a + 1, 8'hEE);
            idle(PC - 5);
        end else begin
            idle(PC - 4);
        end
        check(busy == 1'b1, "R4 busy held for programming time", busy, 1);
        idle(1);
        check(busy == 1'b0, "R4 busy falls after programming time", busy, 0);
        for (int k = 0; k < pend_off.size(); k++)
            model[(cur_pg << PBITS) + pend_off[k]] = pend_dat[k];
        pend_off.delete();
        pend_dat.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) model[a] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
        rd(10'h005, 8'h00, "R1");
        rd(10'h3FF, 8'h00, "R1");

        // Single byte with bit 7 set
        ld(10'h005, 8'hA5);
        run_window(10'h005, 1'b0);
        rd(10'h005, model[10'h005], "R6");
        rd(10'h004, 8'h00, "R7");
        rd(10'h006, 8'h00, "R7");

        // Retriggered burst, duplicate offset, foreign page bits
        ld(10'h100, 8'h11);
        idle(LT - 2);
        check(busy == 1'b0, "R3 retrigger keeps window open", busy, 0);
        ld(10'h101, 8'h22);
        rd(10'h100, 8'h00, "R2 load not visible");
        idle(LT - 3);
        check(busy == 1'b0, "R3 retrigger keeps window open", busy, 0);
        ld(10'h101, 8'h77);
        ld(10'h290, 8'h5A);
        ld(10'h17F, 8'h3C);
        run_window(10'h17F, 1'b0);
        rd(10'h100, 8'h11, "R6");
        rd(10'h101, 8'h77, "R10");
        rd(10'h110, 8'h5A, "R8");
        rd(10'h290, 8'h00, "R8");
        rd(10'h17F, 8'h3C, "R6");
        rd(10'h102, 8'h00, "R7");
        rd(10'h005, 8'hA5, "R7");

        // Strobe during programming is ignored
        ld(10'h200, 8'h80);
        run_window(10'h200, 1'b1);
        rd(10'h200, 8'h80, "R6");
        rd(10'h201, 8'h00, "R9");
        idle(LT + 5);
        check(busy == 1'b0, "R9 no load started by ignored strobe", busy, 0);
        rd(10'h201, 8'h00, "R9");

        // Full page, same programming length
        for (int i = 0; i < (1 << PBITS); i++) ld(10'h300 + i, 8'((i * 3 + 7) & 8'hFF));
        run_window(10'h37F, 1'b0);
        for (int i = 0; i < (1 << PBITS); i++) rd(10'h300 + i, model[10'h300 + i], "R6 full page");
        rd(10'h2FF, 8'h00, "R7");

        idle(3);
        summary();
    end
endmodule